// File: doc/BRIEF.md
# Shift-Only One-Pole Lowpass Smoother

This block steadies a slow measurement stream, such as the sum of samples taken over one mains period. Each time a new value arrives with its strobe, the stored estimate moves toward it by a fixed fraction, 1/2^N of the gap. The block needs no multiplier. The new estimate is formed as the old estimate shifted up by N places, less the old estimate, plus the new value, and that total is shifted down by N places. The result feeds a thyristor control loop, which then sees a cleaner view of the period average.

The filter updates only on strobed cycles, so it runs at the period rate and not at the sampling rate. Its DC gain is one. Its time constant is −1/ln(1 − 2^−N) update periods, so the shift count N is the only tuning knob. N is a compile-time parameter that may range from 1 to 8. The internal sum is sized so that it cannot wrap.

Top module: `ema_smoother`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `smooth_out` becomes 0 after that edge.
- R2: On an edge where `sample_vld` is high and `rst_n` is high, `smooth_out` becomes floor((Y·2^N − Y + X) / 2^N). Here Y is the previous output and X is `sample_in`, and both are treated as unsigned. With N = 4 and starting from 0, an input of 1600 gives 100 and then 193.
- R3: On an edge where `sample_vld` is low, `smooth_out` keeps its value, whatever `sample_in` carries.
- R4: A full-scale input, held for any number of updates, never makes the output wrap or fall. The internal sum is IN_W + N + 1 bits wide, and its top bit stays 0.
- R5: When the input is at or above the output, an update never lowers the output and never moves it past the input. Held at a constant X from below, the output settles within 2^N − 1 LSB under X.
- R6: When `rst_n` is low and `sample_vld` is high in the same cycle, reset wins and the output becomes 0.
- R7: When the input is below the output, an update never raises the output and never moves it below the input. Held at a constant X from above, the output reaches exactly X.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sample_vld | input | 1 | Strobe: one update on this edge |
| sample_in | input | IN_W | New per-period value, unsigned |
| smooth_out | output | IN_W | Registered filtered estimate, unsigned |

## Verification
Reset and an update are the two functions that can land on the same edge. To provoke the collision, the bench first drives the output to a non-zero value. It then pulls `rst_n` low in the same cycle that it raises `sample_vld` with a large input. The check passes only if the output reads 0 after that edge. The next strobed update after release must then start from 0, as the bench's reference model expects.

// File: rtl/ema_smooth_pkg.sv
// Package: shared sizing helpers for the shift-only smoother.
// Assumes: unsigned data, a shift count of 1..8 chosen at compile time.
package ema_smooth_pkg;

    localparam int unsigned SHIFT_MIN = 1;
    localparam int unsigned SHIFT_MAX = 8;

    // Width of the update sum: data bits, shift headroom, one guard bit.
    function automatic int unsigned acc_width(input int unsigned data_w,
                                              input int unsigned shift_n);
        return data_w + shift_n + 1;
    endfunction

endpackage

// File: rtl/ema_step_calc.sv
// Module: ema_step_calc
// Forms the next estimate from the current one and a new value, using only
// a shift, one subtract and one add, then truncates by SHIFT_N places.
// Assumes: both operands are unsigned and ACC_W is at least DATA_W+SHIFT_N.
module ema_step_calc
    import ema_smooth_pkg::*;
#(
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned SHIFT_N = 4,
    localparam int unsigned ACC_W  = acc_width(DATA_W, SHIFT_N)
) (
    input  logic [DATA_W-1:0] cur_est,
    input  logic [DATA_W-1:0] new_val,
    output logic [DATA_W-1:0] next_est,
    output logic [ACC_W-1:0]  acc_sum
);

    logic [ACC_W-1:0] est_wide;
    logic [ACC_W-1:0] val_wide;
    logic [ACC_W-1:0] est_scaled;

    // Widen the operands and scale the current estimate by 2^SHIFT_N.
    always_comb begin
        est_wide   = ACC_W'(cur_est);
        val_wide   = ACC_W'(new_val);
        est_scaled = est_wide << SHIFT_N;
    end

    // Scaled estimate less one copy of itself, plus the new value.
    always_comb begin
        acc_sum = est_scaled - est_wide + val_wide;
    end

    // Divide by 2^SHIFT_N through truncation: keep the bits above the shift.
    always_comb begin
        next_est = acc_sum[SHIFT_N +: DATA_W];
    end

endmodule

// File: rtl/ema_state_reg.sv
// Module: ema_state_reg
// Holds the filter estimate. Loads on a strobe, holds otherwise, and clears
// on a synchronous active-low reset that takes priority over the load.
// Assumes: load_en is synchronous to clk.
module ema_state_reg #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] state_q
);

    // Estimate register: reset beats load, load beats hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else if (load_en) begin
            state_q <= load_val;
        end
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> state_q == '0); // R1
    AST_RESET_OVER_LOAD: assert property (@(posedge clk) (!rst_n && load_en) |=> state_q == '0); // R6
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !load_en |=> $stable(state_q)); // R3

endmodule

// File: rtl/ema_smoother.sv
// Module: ema_smoother (top)
// One-pole lowpass smoother with unity DC gain. Each strobe moves the stored
// estimate 1/2^SHIFT_N of the way toward the new input, with no multiplier.
// Assumes: unsigned input, one strobe per measurement period, SHIFT_N 1..8.
module ema_smoother
    import ema_smooth_pkg::*;
#(
    parameter int unsigned IN_W    = 16,
    parameter int unsigned SHIFT_N = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sample_vld,
    input  logic [IN_W-1:0] sample_in,
    output logic [IN_W-1:0] smooth_out
);

    localparam int unsigned ACC_W = acc_width(IN_W, SHIFT_N);

    logic [IN_W-1:0]  est_q;
    logic [IN_W-1:0]  est_next;
    logic [ACC_W-1:0] step_sum;

    // Refuse an out-of-range shift count when the design is elaborated.
    generate
        if (SHIFT_N < SHIFT_MIN || SHIFT_N > SHIFT_MAX) begin : g_bad_shift
            $error("ema_smoother: SHIFT_N must lie in 1..8");
        end
    endgenerate

    ema_step_calc #(
        .DATA_W  (IN_W),
        .SHIFT_N (SHIFT_N)
    ) u_calc (
        .cur_est  (est_q),
        .new_val  (sample_in),
        .next_est (est_next),
        .acc_sum  (step_sum)
    );

    ema_state_reg #(
        .DATA_W (IN_W)
    ) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (sample_vld),
        .load_val (est_next),
        .state_q  (est_q)
    );

    // Drive the port from the estimate register.
    always_comb begin
        smooth_out = est_q;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) step_sum[ACC_W-1] == 1'b0); // R4
    AST_RISE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && sample_in >= smooth_out) |=>
        (smooth_out >= $past(smooth_out) && smooth_out <= $past(sample_in))); // R5
    AST_FALL_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && sample_in < smooth_out) |=>
        (smooth_out <= $past(smooth_out) && smooth_out >= $past(sample_in))); // R7

endmodule

// File: tb/ema_smoother_test.sv
`timescale 1ns/1ps
// Directed bench for ema_smoother: one task per scenario, each checking
// its own results against a reference model of the update rule.
module ema_smoother_test;

    localparam int unsigned W  = 16;
    localparam int unsigned SN = 4;
    localparam longint FULL    = (64'd1 << W) - 1;
    localparam longint TOL     = (64'd1 << SN) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sample_vld;
    logic [W-1:0]  sample_in;
    logic [W-1:0]  smooth_out;

    int     errors = 0;
    int     checks = 0;
    longint ref_y  = 0;

    always #5 clk = ~clk;

    ema_smoother #(.IN_W(W), .SHIFT_N(SN)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_vld (sample_vld),
        .sample_in  (sample_in),
        .smooth_out (smooth_out)
    );

    // Reference update: floor((Y*2^N - Y + X) / 2^N), computed in wide integers.
    function automatic longint model_next(longint y, longint x);
        return (y * (64'd1 << SN) - y + x) / (64'd1 << SN);
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One strobed update, sampled at the falling edge after the load edge.
    task automatic do_update(input longint x, input string tag);
        @(negedge clk);
        sample_in  = W'(x);
        sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
        ref_y = model_next(ref_y, x);
        check(longint'(smooth_out) == ref_y, tag, longint'(smooth_out), ref_y);
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0; sample_vld = 1'b0; sample_in = '0;
        @(negedge clk);
        @(negedge clk);
        ref_y = 0;
        check(smooth_out == '0, "R1 reset value", longint'(smooth_out), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_known_steps;
        do_update(1600, "R2 first step");
        check(longint'(smooth_out) == 100, "R2 literal 100", longint'(smooth_out), 100);
        do_update(1600, "R2 second step");
        check(longint'(smooth_out) == 193, "R2 literal 193", longint'(smooth_out), 193);
    endtask

    task automatic t_hold;
        longint held;
        do_update(500, "R2 before hold");
        held = longint'(smooth_out);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            sample_in = W'(64'd9000 + i * 7777);
            sample_vld = 1'b0;
            @(negedge clk);
            check(longint'(smooth_out) == held, "R3 idle hold", longint'(smooth_out), held);
        end
    endtask

    task automatic t_gapped;
        for (int k = 0; k < 8; k++) begin
            do_update(3000 + k * 450, "R2 gapped update");
            for (int g = 0; g < k; g++) begin
                @(negedge clk);
                sample_in = W'(64'd60000 - g);
            end
            @(negedge clk);
            check(longint'(smooth_out) == ref_y, "R3 gap hold", longint'(smooth_out), ref_y);
        end
    endtask

    task automatic t_converge_up;
        longint x = 41000;
        longint prev;
        t_reset();
        for (int i = 0; i < 300; i++) begin
            prev = longint'(smooth_out);
            do_update(x, "R2 rising");
            check(longint'(smooth_out) >= prev && longint'(smooth_out) <= x,
                  "R5 rise bounded", longint'(smooth_out), x);
        end
        check(longint'(smooth_out) <= x && x - longint'(smooth_out) <= TOL,
              "R5 settle below input", longint'(smooth_out), x);
    endtask

    task automatic t_decay_down;
        longint x = 200;
        longint prev;
        for (int i = 0; i < 400; i++) begin
            prev = longint'(smooth_out);
            do_update(x, "R2 falling");
            check(longint'(smooth_out) <= prev && longint'(smooth_out) >= x,
                  "R7 fall bounded", longint'(smooth_out), x);
        end
        check(longint'(smooth_out) == x, "R7 exact settle", longint'(smooth_out), x);
    endtask

    task automatic t_full_scale;
        longint prev;
        t_reset();
        for (int i = 0; i < 300; i++) begin
            prev = longint'(smooth_out);
            do_update(FULL, "R2 full scale");
            check(longint'(smooth_out) >= prev, "R4 no wrap", longint'(smooth_out), prev);
        end
        check(FULL - longint'(smooth_out) <= TOL, "R4 near full", longint'(smooth_out), FULL);
    endtask

    task automatic t_reset_priority;
        do_update(30000, "R2 preload");
        check(smooth_out != '0, "R6 preload nonzero", longint'(smooth_out), 1);
        @(negedge clk);
        rst_n = 1'b0; sample_vld = 1'b1; sample_in = W'(64'd50000);
        @(negedge clk);
        check(smooth_out == '0, "R6 reset wins", longint'(smooth_out), 0);
        rst_n = 1'b1; sample_vld = 1'b0;
        ref_y = 0;
        do_update(800, "R6 restart from zero");
        check(longint'(smooth_out) == 50, "R6 restart value", longint'(smooth_out), 50);
    endtask

    bit done = 1'b0;

    initial begin
        rst_n = 1'b0; sample_vld = 1'b0; sample_in = '0;
        t_reset();
        t_known_steps();
        t_hold();
        t_gapped();
        t_converge_up();
        t_decay_down();
        t_full_scale();
        t_reset_priority();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1900000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule